// File: doc/BRIEF.md
# Dual-Write Dual-Read Register File

This block is a small synchronous register file. It holds sixteen 8-bit entries and has four independent ports: two write ports (A and B) and two read ports (A and B). All four can be used in the same cycle. Each write port has an address, a data word and an enable. An enabled write is committed on the rising clock edge. Each read port returns the addressed entry combinationally, so its output follows the read address and the stored contents within the same cycle.

When both write ports target the same entry in one cycle, a fixed priority decides the result: the value from write port A is stored and write port B's value is dropped. The contents are never cleared. An asynchronous active-low reset only blocks writes, and it is released through a two-stage synchronizer, so the stored data survives a reset pulse.

Top module: `rf_dual_wr`

## Requirements
- R1: The file holds 16 entries of 8 bits each, addressed by 4-bit addresses. A write port with its enable high stores its data at its address on the rising clock edge.
- R2: The two read ports are independent. Each drives the entry at its own address, combinationally and in the same cycle, and both can read any entries at once.
- R3: When both write ports are enabled with different addresses in one cycle, both addressed entries take their port's data at that edge.
- R4: When both write ports are enabled with the same address in one cycle, the entry takes write port A's data and write port B's data is discarded.
- R5: A write port whose enable is low has no effect. When only one port is enabled at a shared address, that port's data is stored whether it is port A or port B. When neither port is enabled, no entry changes.
- R6: A stored value does not change while other entries are written.
- R7: Reading an entry in the cycle it is written returns the old value until the clock edge, and the new value after the edge. There is no bypass.
- R8: While rst_ni is low, no write is committed and the contents are kept. After rst_ni rises, writes take effect from the third rising edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset; blocks writes only |
| wa_en_i | input | 1 | Write port A enable |
| wa_addr_i | input | 4 | Write port A entry address |
| wa_data_i | input | 8 | Write port A data |
| wb_en_i | input | 1 | Write port B enable |
| wb_addr_i | input | 4 | Write port B entry address |
| wb_data_i | input | 8 | Write port B data |
| ra_addr_i | input | 4 | Read port A address |
| ra_data_o | output | 8 | Read port A data |
| rb_addr_i | input | 4 | Read port B address |
| rb_data_o | output | 8 | Read port B data |

## Verification
The bench first fills every entry with pairs of writes to distinct addresses. It then steps through a vector table that mixes four cases: both ports at different addresses, both ports at one address, a single port enabled at an address the other port also names, and no port enabled. These cases separate a broken priority from a broken enable gate. After each step, both read ports sweep the whole file, which exposes decode aliasing and stray writes to bystander entries. A collision on each of the sixteen addresses catches priority logic that fails on only some entries. Directed tests then read an entry during its own write cycle to show there is no bypass, and check that writes are blocked during reset and in the two cycles after its release.

// File: rtl/rf_dual_wr_pkg.sv
`timescale 1ns/1ps
package rf_dual_wr_pkg;
  // Source selected for one entry in one cycle
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_PORTA = 2'd1,
    SRC_PORTB = 2'd2
  } rf_src_e;

  // Port A has fixed priority over port B on the same entry
  function automatic rf_src_e pick_src(input logic hit_a, input logic hit_b);
    if (hit_a)      return SRC_PORTA;
    else if (hit_b) return SRC_PORTB;
    else            return SRC_HOLD;
  endfunction
endpackage

// File: rtl/rf_rst_sync.sv
`timescale 1ns/1ps
module rf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign ready_o = sync_q[STAGES-1];
endmodule

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
module rf_wr_decode #(
  parameter int NUM_ENT = 16,
  parameter int ADDR_W  = $clog2(NUM_ENT)
) (
  input  logic               en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_ENT-1:0] hit_o
);
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign hit_o[e] = en_i && (addr_i == ADDR_W'(e));
  end
endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage
  import rf_dual_wr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_ENT = 16
) (
  input  logic                           clk_i,
  input  logic                           allow_i,
  input  logic [NUM_ENT-1:0]             hit_a_i,
  input  logic [DATA_W-1:0]              data_a_i,
  input  logic [NUM_ENT-1:0]             hit_b_i,
  input  logic [DATA_W-1:0]              data_b_i,
  output logic [NUM_ENT-1:0][DATA_W-1:0] mem_o
);
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    rf_src_e           src;
    logic              ce;
    logic [DATA_W-1:0] ent_d;
    logic [DATA_W-1:0] ent_q;

    always_comb begin
      src = pick_src(hit_a_i[e], hit_b_i[e]);
      ce  = allow_i && (src != SRC_HOLD);
      unique case (src)
        SRC_PORTA: ent_d = data_a_i;
        SRC_PORTB: ent_d = data_b_i;
        default:   ent_d = ent_q;
      endcase
    end

    always_ff @(posedge clk_i) begin
      if (ce) ent_q <= ent_d;
    end

    assign mem_o[e] = ent_q;
  end
endmodule

// File: rtl/rf_read_mux.sv
`timescale 1ns/1ps
module rf_read_mux #(
  parameter int DATA_W  = 8,
  parameter int NUM_ENT = 16,
  parameter int NUM_RD  = 2,
  parameter int ADDR_W  = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0][DATA_W-1:0] mem_i,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  addr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  data_o
);
  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    always_comb begin
      data_o[p] = '0;
      for (int e = 0; e < NUM_ENT; e++) begin
        if (addr_i[p] == ADDR_W'(e)) data_o[p] = mem_i[e];
      end
    end
  end
endmodule

// File: rtl/rf_dual_wr.sv
`timescale 1ns/1ps
module rf_dual_wr #(
  parameter int DATA_W  = 8,
  parameter int NUM_ENT = 16,
  localparam int ADDR_W = $clog2(NUM_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wa_en_i,
  input  logic [ADDR_W-1:0] wa_addr_i,
  input  logic [DATA_W-1:0] wa_data_i,
  input  logic              wb_en_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic [ADDR_W-1:0] ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o
);
  localparam int NUM_RD = 2;

  logic                           wr_allow;
  logic [NUM_ENT-1:0]             hit_a;
  logic [NUM_ENT-1:0]             hit_b;
  logic [NUM_ENT-1:0][DATA_W-1:0] mem_q;
  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0]  rd_data;

  rf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_o (wr_allow)
  );

  rf_wr_decode #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_dec_a (
    .en_i   (wa_en_i),
    .addr_i (wa_addr_i),
    .hit_o  (hit_a)
  );

  rf_wr_decode #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_dec_b (
    .en_i   (wb_en_i),
    .addr_i (wb_addr_i),
    .hit_o  (hit_b)
  );

  rf_storage #(.DATA_W(DATA_W), .NUM_ENT(NUM_ENT)) u_store (
    .clk_i    (clk_i),
    .allow_i  (wr_allow),
    .hit_a_i  (hit_a),
    .data_a_i (wa_data_i),
    .hit_b_i  (hit_b),
    .data_b_i (wb_data_i),
    .mem_o    (mem_q)
  );

  assign rd_addr = {rb_addr_i, ra_addr_i};

  rf_read_mux #(
    .DATA_W(DATA_W), .NUM_ENT(NUM_ENT), .NUM_RD(NUM_RD), .ADDR_W(ADDR_W)
  ) u_rd (
    .mem_i  (mem_q),
    .addr_i (rd_addr),
    .data_o (rd_data)
  );

  assign ra_data_o = rd_data[0];
  assign rb_data_o = rd_data[1];
endmodule

// File: rtl/rf_dual_wr_chk.sv
`timescale 1ns/1ps
module rf_dual_wr_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_ENT = 16,
  parameter int ADDR_W  = $clog2(NUM_ENT)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wa_en_i,
  input logic [ADDR_W-1:0]              wa_addr_i,
  input logic [DATA_W-1:0]              wa_data_i,
  input logic                           wb_en_i,
  input logic [ADDR_W-1:0]              wb_addr_i,
  input logic [DATA_W-1:0]              wb_data_i,
  input logic [ADDR_W-1:0]              ra_addr_i,
  input logic [DATA_W-1:0]              ra_data_o,
  input logic [ADDR_W-1:0]              rb_addr_i,
  input logic [DATA_W-1:0]              rb_data_o,
  input logic                           wr_allow,
  input logic [NUM_ENT-1:0][DATA_W-1:0] mem_q
);
  a_r3_both_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_allow && wa_en_i && wb_en_i && wa_addr_i != wb_addr_i)
    |=> (mem_q[$past(wa_addr_i)] == $past(wa_data_i)) &&
        (mem_q[$past(wb_addr_i)] == $past(wb_data_i)));

  a_r4_port_a_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_allow && wa_en_i && wb_en_i && wa_addr_i == wb_addr_i)
    |=> mem_q[$past(wa_addr_i)] == $past(wa_data_i));

  a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wa_en_i && !wb_en_i) |=> $stable(mem_q));

  a_r2_read_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_data_o == mem_q[ra_addr_i]);

  a_r2_read_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_data_o == mem_q[rb_addr_i]);

  a_r8_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_allow |=> $stable(mem_q));
endmodule

bind rf_dual_wr rf_dual_wr_chk #(
  .DATA_W(DATA_W), .NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wa_en_i   (wa_en_i),
  .wa_addr_i (wa_addr_i),
  .wa_data_i (wa_data_i),
  .wb_en_i   (wb_en_i),
  .wb_addr_i (wb_addr_i),
  .wb_data_i (wb_data_i),
  .ra_addr_i (ra_addr_i),
  .ra_data_o (ra_data_o),
  .rb_addr_i (rb_addr_i),
  .rb_data_o (rb_data_o),
  .wr_allow  (wr_allow),
  .mem_q     (mem_q)
);

// File: tb/rf_dual_wr_tb.sv
`timescale 1ns/1ps
module rf_dual_wr_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wa_en, wb_en;
  logic [3:0] wa_addr, wb_addr, ra_addr, rb_addr;
  logic [7:0] wa_data, wb_data, ra_data, rb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #10 clk = ~clk;

  rf_dual_wr u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wa_en_i(wa_en), .wa_addr_i(wa_addr), .wa_data_i(wa_data),
    .wb_en_i(wb_en), .wb_addr_i(wb_addr), .wb_data_i(wb_data),
    .ra_addr_i(ra_addr), .ra_data_o(ra_data),
    .rb_addr_i(rb_addr), .rb_data_o(rb_data)
  );

  // {en_a, addr_a, data_a, en_b, addr_b, data_b}
  localparam int NVEC = 10;
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 4'd2,  8'hA5, 1'b1, 4'd9,  8'h5A},  // R3
    {1'b1, 4'd4,  8'h11, 1'b1, 4'd4,  8'h22},  // R4
    {1'b1, 4'd7,  8'hC3, 1'b0, 4'd7,  8'h3C},  // R5 A only
    {1'b0, 4'd7,  8'hEE, 1'b1, 4'd7,  8'h77},  // R5 B only
    {1'b0, 4'd1,  8'hFF, 1'b0, 4'd2,  8'hFF},  // R5 idle
    {1'b1, 4'd15, 8'h80, 1'b1, 4'd15, 8'h01},  // R4
    {1'b1, 4'd0,  8'h00, 1'b1, 4'd0,  8'hFF},  // R4
    {1'b1, 4'd14, 8'h0E, 1'b1, 4'd0,  8'hF0},  // R3
    {1'b0, 4'd3,  8'h99, 1'b1, 4'd13, 8'hD3},  // R5
    {1'b1, 4'd8,  8'h81, 1'b0, 4'd5,  8'h55}   // R6
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  // Sweep the whole file through both read ports (R2, R6)
  task automatic sweep(input string req);
    for (int i = 0; i < 8; i++) begin
      ra_addr = 4'(i);
      rb_addr = 4'(i + 8);
      #1;
      chk(req, ra_data, model[i]);
      chk(req, rb_data, model[i + 8]);
    end
  endtask

  // Apply one write cycle at a falling edge; the edge after commits it
  task automatic wr_cycle(input logic ea, input logic [3:0] aa, input logic [7:0] da,
                          input logic eb, input logic [3:0] ab, input logic [7:0] db);
    @(negedge clk);
    wa_en = ea; wa_addr = aa; wa_data = da;
    wb_en = eb; wb_addr = ab; wb_data = db;
    @(negedge clk);
    wa_en = 1'b0; wb_en = 1'b0;
    if (eb) model[ab] = db;
    if (ea) model[aa] = da;
  endtask

  initial begin
    rst_n = 1'b0;
    wa_en = 1'b0; wb_en = 1'b0;
    wa_addr = '0; wb_addr = '0; wa_data = '0; wb_data = '0;
    ra_addr = '0; rb_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R3: fill every entry, two distinct addresses per cycle
    for (int i = 0; i < 8; i++)
      wr_cycle(1'b1, 4'(i), 8'(8'h10 + i), 1'b1, 4'(i + 8), 8'(8'hC0 + i));
    sweep("R1");

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      wr_cycle(VEC[v][25], VEC[v][24:21], VEC[v][20:13],
               VEC[v][12], VEC[v][11:8], VEC[v][7:0]);
      sweep("R5");
    end

    // R4: collision on every address
    for (int e = 0; e < 16; e++) begin
      wr_cycle(1'b1, 4'(e), 8'(e * 13 + 5), 1'b1, 4'(e), ~8'(e * 13 + 5));
      ra_addr = 4'(e); #1;
      chk("R4", ra_data, 8'(e * 13 + 5));
    end
    sweep("R6");

    // R7: read during write shows old value until the edge
    @(negedge clk);
    wa_en = 1'b1; wa_addr = 4'd6; wa_data = 8'h6B;
    ra_addr = 4'd6; rb_addr = 4'd6;
    #2;
    chk("R7", ra_data, model[6]);
    chk("R7", rb_data, model[6]);
    @(negedge clk);
    wa_en = 1'b0;
    model[6] = 8'h6B;
    #2;
    chk("R7", ra_data, 8'h6B);

    // R8: writes blocked in reset, contents kept
    @(negedge clk);
    rst_n = 1'b0;
    wa_en = 1'b1; wa_addr = 4'd2; wa_data = 8'h3E;
    wb_en = 1'b1; wb_addr = 4'd9; wb_data = 8'h9E;
    repeat (2) @(negedge clk);
    ra_addr = 4'd2; rb_addr = 4'd9; #1;
    chk("R8", ra_data, model[2]);
    chk("R8", rb_data, model[9]);
    wb_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R8", ra_data, model[2]);
    @(negedge clk);
    wa_en = 1'b0;
    model[2] = 8'h3E;
    #1;
    chk("R8", ra_data, 8'h3E);
    sweep("R8");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule